// File: doc/BRIEF.md
# Halfword-Select Signed Multiply-Accumulator

This block executes one DSP-style instruction per clock. It takes a 32-bit instruction word, two 32-bit operand registers and the current processor flags. The instruction word chooses the upper or lower 16-bit half of each operand. The two halves are multiplied as signed values. The 32-bit product is sign-extended and added into a 40-bit accumulator.

The update happens only when three things hold: the valid strobe is high, the fixed opcode bits of the word match, and the 4-bit condition field passes against the flags. The block never changes the flags. A word that fails the opcode check raises a no-match output in the same cycle, and the accumulator is left alone.

A direct load port writes any 40-bit value into the accumulator. It is used to seed the accumulator before a run and in tests. An asynchronous active-low reset clears the accumulator.

Top module: `hsel_mac`

## Requirements
- R1: While `rst_n` is low the accumulator output `acc_o` is zero.
- R2: A valid word whose opcode matches and whose condition passes sets `acc_o`, one clock later, to the old value plus the sign-extended product of the two selected halves.
- R3: Instruction bit 17 picks the multiplicand half: 0 takes `mcand_i[15:0]`, 1 takes `mcand_i[31:16]`.
- R4: Instruction bit 16 picks the multiplier half: 0 takes `mplier_i[15:0]`, 1 takes `mplier_i[31:16]`.
- R5: Both halves are two's-complement signed. The 32-bit product is sign-extended to 40 bits before the add.
- R6: The 40-bit sum wraps modulo 2^40.
- R7: The condition field `instr_i[31:28]` is tested against `flags_i`, packed as {N,Z,C,V} in bits 3..0. The codes are:
  - 0: Z
  - 1: !Z
  - 2: C
  - 3: !C
  - 4: N
  - 5: !N
  - 6: V
  - 7: !V
  - 8: C&!Z
  - 9: !C|Z
  - A: N==V
  - B: N!=V
  - C: !Z&(N==V)
  - D: Z|(N!=V)
  - E: always
  - F: never

  A failed condition leaves `acc_o` unchanged.
- R8: The opcode matches only when `instr_i[27:18]` = 1110001011 and `instr_i[11:4]` = 00000001. A valid word that does not match drives `nomatch_o` high in the same cycle and leaves `acc_o` unchanged.
- R9: `nomatch_o` is low whenever `valid_i` is low, and low for a valid matching word.
- R10: `load_i` writes `load_val_i` into the accumulator, visible one clock later. A load takes priority over an instruction issued in the same cycle.
- R11: With neither `valid_i` nor `load_i` high, `acc_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction strobe |
| instr_i | input | 32 | Instruction word |
| mcand_i | input | 32 | Multiplicand register value |
| mplier_i | input | 32 | Multiplier register value |
| flags_i | input | 4 | Flags {N,Z,C,V} |
| load_i | input | 1 | Direct accumulator load strobe |
| load_val_i | input | 40 | Value for direct load |
| acc_o | output | 40 | Accumulator |
| nomatch_o | output | 1 | Valid word failed opcode check |

## Verification
Results arrive at two different times:
- Accumulator results, from both instructions and loads, pass through one register. They are due at the first rising edge after the strobe.
- `nomatch_o` is combinational. It is due in the same cycle the word is driven.

The bench drives inputs on the falling edge. It samples `nomatch_o` one time step later, while the inputs are still held. It reads `acc_o` on the next falling edge, after exactly one rising edge has passed. Cases that must leave the accumulator alone are checked at that same sample point, against the value held before the strobe.

// File: rtl/hsel_mac_pkg.sv
package hsel_mac_pkg;

  localparam int unsigned INSTR_W = 32;
  localparam logic [9:0]  OPC_HI  = 10'b1110001011;  // instr[27:18]
  localparam logic [7:0]  OPC_MID = 8'b00000001;     // instr[11:4]

  typedef enum logic [3:0] {
    CC_EQ = 4'h0, CC_NE = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
    CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
    CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
    CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

endpackage

// File: rtl/hsel_mac_decode.sv
module hsel_mac_decode
  import hsel_mac_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output logic               match_o,
  output cond_e              cond_o,
  output logic               hi_a_o,
  output logic               hi_b_o
);

  // Register numbers are resolved outside this unit.
  logic unused_reg_idx;
  assign unused_reg_idx = ^{instr_i[15:12], instr_i[3:0]};

  always_comb begin
    match_o = (instr_i[27:18] == OPC_HI) && (instr_i[11:4] == OPC_MID);
    cond_o  = cond_e'(instr_i[31:28]);
    hi_a_o  = instr_i[17];
    hi_b_o  = instr_i[16];
  end

endmodule

// File: rtl/hsel_mac_cond.sv
module hsel_mac_cond
  import hsel_mac_pkg::*;
(
  input  cond_e  cond_i,
  input  flags_t flags_i,
  output logic   pass_o
);

  logic n_eq_v;
  assign n_eq_v = (flags_i.n == flags_i.v);

  always_comb begin
    unique case (cond_i)
      CC_EQ:   pass_o = flags_i.z;
      CC_NE:   pass_o = !flags_i.z;
      CC_CS:   pass_o = flags_i.c;
      CC_CC:   pass_o = !flags_i.c;
      CC_MI:   pass_o = flags_i.n;
      CC_PL:   pass_o = !flags_i.n;
      CC_VS:   pass_o = flags_i.v;
      CC_VC:   pass_o = !flags_i.v;
      CC_HI:   pass_o = flags_i.c && !flags_i.z;
      CC_LS:   pass_o = !flags_i.c || flags_i.z;
      CC_GE:   pass_o = n_eq_v;
      CC_LT:   pass_o = !n_eq_v;
      CC_GT:   pass_o = !flags_i.z && n_eq_v;
      CC_LE:   pass_o = flags_i.z || !n_eq_v;
      CC_AL:   pass_o = 1'b1;
      default: pass_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/hsel_mac_datapath.sv
module hsel_mac_datapath #(
  parameter int unsigned ACC_W  = 40,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HALF_W = 16
) (
  input  logic [DATA_W-1:0] mcand_i,
  input  logic [DATA_W-1:0] mplier_i,
  input  logic              hi_a_i,
  input  logic              hi_b_i,
  input  logic [ACC_W-1:0]  acc_i,
  output logic [ACC_W-1:0]  sum_o
);

  localparam int unsigned PROD_W = 2 * HALF_W;
  localparam int unsigned EXT_W  = ACC_W - PROD_W;

  logic signed [HALF_W-1:0] op_a;
  logic signed [HALF_W-1:0] op_b;
  logic signed [PROD_W-1:0] prod;
  logic        [ACC_W-1:0]  prod_ext;

  always_comb begin
    op_a = hi_a_i ? mcand_i[DATA_W-1 -: HALF_W]  : mcand_i[HALF_W-1:0];
    op_b = hi_b_i ? mplier_i[DATA_W-1 -: HALF_W] : mplier_i[HALF_W-1:0];
    prod = op_a * op_b;
  end

  generate
    if (EXT_W > 0) begin : g_ext
      assign prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};
    end else begin : g_noext
      assign prod_ext = prod[ACC_W-1:0];
    end
  endgenerate

  assign sum_o = acc_i + prod_ext;

endmodule

// File: rtl/hsel_mac.sv
module hsel_mac
  import hsel_mac_pkg::*;
#(
  parameter int unsigned ACC_W  = 40,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HALF_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  mcand_i,
  input  logic [DATA_W-1:0]  mplier_i,
  input  logic [3:0]         flags_i,
  input  logic               load_i,
  input  logic [ACC_W-1:0]   load_val_i,
  output logic [ACC_W-1:0]   acc_o,
  output logic               nomatch_o
);

  logic             match;
  cond_e            cond;
  logic             hi_a;
  logic             hi_b;
  logic             pass;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic             acc_en;

  hsel_mac_decode u_decode (
    .instr_i (instr_i),
    .match_o (match),
    .cond_o  (cond),
    .hi_a_o  (hi_a),
    .hi_b_o  (hi_b)
  );

  hsel_mac_cond u_cond (
    .cond_i  (cond),
    .flags_i (flags_t'(flags_i)),
    .pass_o  (pass)
  );

  hsel_mac_datapath #(
    .ACC_W  (ACC_W),
    .DATA_W (DATA_W),
    .HALF_W (HALF_W)
  ) u_dp (
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .hi_a_i   (hi_a),
    .hi_b_i   (hi_b),
    .acc_i    (acc_q),
    .sum_o    (sum)
  );

  // Next-state: load wins over an instruction.
  always_comb begin
    acc_d  = acc_q;
    acc_en = 1'b0;
    if (load_i) begin
      acc_d  = load_val_i;
      acc_en = 1'b1;
    end else if (valid_i && match && pass) begin
      acc_d  = sum;
      acc_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  assign acc_o     = acc_q;
  assign nomatch_o = valid_i && !match;

endmodule

// File: rtl/hsel_mac_chk.sv
module hsel_mac_chk #(
  parameter int unsigned ACC_W  = 40,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HALF_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              valid_i,
  input logic [31:0]       instr_i,
  input logic [DATA_W-1:0] mcand_i,
  input logic [DATA_W-1:0] mplier_i,
  input logic [3:0]        flags_i,
  input logic              load_i,
  input logic [ACC_W-1:0]  load_val_i,
  input logic [ACC_W-1:0]  acc_o,
  input logic              nomatch_o
);

  logic                       enc_ok;
  logic signed [HALF_W-1:0]   ha;
  logic signed [HALF_W-1:0]   hb;
  logic signed [2*HALF_W-1:0] p;
  logic        [ACC_W-1:0]    step;

  always_comb begin
    enc_ok = (instr_i[27:18] == 10'b1110001011) && (instr_i[11:4] == 8'h01);
    ha     = instr_i[17] ? mcand_i[DATA_W-1 -: HALF_W]  : mcand_i[HALF_W-1:0];
    hb     = instr_i[16] ? mplier_i[DATA_W-1 -: HALF_W] : mplier_i[HALF_W-1:0];
    p      = ha * hb;
    step   = ACC_W'(p);
  end

  logic unused_flags;
  assign unused_flags = ^flags_i;

  a_r1_reset_zero: assert property (@(posedge clk)
    $rose(rst_n) |-> acc_o == '0);

  a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> acc_o == $past(load_val_i));

  a_r2_always_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !load_i && enc_ok && instr_i[31:28] == 4'hE)
      |=> acc_o == $past(acc_o + step));

  a_r7_never_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !load_i && instr_i[31:28] == 4'hF) |=> $stable(acc_o));

  a_r8_nomatch_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !enc_ok) |-> nomatch_o);

  a_r8_nomatch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !enc_ok && !load_i) |=> $stable(acc_o));

  a_r9_quiet_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i || enc_ok) |-> !nomatch_o);

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i && !load_i) |=> $stable(acc_o));

endmodule

bind hsel_mac hsel_mac_chk #(
  .ACC_W  (ACC_W),
  .DATA_W (DATA_W),
  .HALF_W (HALF_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .valid_i    (valid_i),
  .instr_i    (instr_i),
  .mcand_i    (mcand_i),
  .mplier_i   (mplier_i),
  .flags_i    (flags_i),
  .load_i     (load_i),
  .load_val_i (load_val_i),
  .acc_o      (acc_o),
  .nomatch_o  (nomatch_o)
);

// File: tb/hsel_mac_bench.sv
module hsel_mac_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ACC_W      = 40;

  logic             clk;
  logic             rst_n;
  logic             valid_i;
  logic [31:0]      instr_i;
  logic [31:0]      mcand_i;
  logic [31:0]      mplier_i;
  logic [3:0]       flags_i;
  logic             load_i;
  logic [ACC_W-1:0] load_val_i;
  logic [ACC_W-1:0] acc_o;
  logic             nomatch_o;

  int n_chk;
  int n_fail;
  bit done;
  logic [ACC_W-1:0] exp_acc;

  hsel_mac u_hsel_mac (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (valid_i),
    .instr_i    (instr_i),
    .mcand_i    (mcand_i),
    .mplier_i   (mplier_i),
    .flags_i    (flags_i),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .acc_o      (acc_o),
    .nomatch_o  (nomatch_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mk(input logic [3:0] cc, input logic x, input logic y);
    return {cc, 10'b1110001011, x, y, 4'h3, 8'h01, 4'h5};
  endfunction

  function automatic bit cond_ok(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      4'h0: return z;
      4'h1: return !z;
      4'h2: return c;
      4'h3: return !c;
      4'h4: return n;
      4'h5: return !n;
      4'h6: return v;
      4'h7: return !v;
      4'h8: return c && !z;
      4'h9: return !c || z;
      4'hA: return n == v;
      4'hB: return n != v;
      4'hC: return !z && (n == v);
      4'hD: return z || (n != v);
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [ACC_W-1:0] product_ext(input logic [31:0] a, input logic [31:0] b,
                                                   input logic x, input logic y);
    logic signed [15:0] ha, hb;
    logic signed [31:0] p;
    ha = x ? a[31:16] : a[15:0];
    hb = y ? b[31:16] : b[15:0];
    p  = ha * hb;
    return {{8{p[31]}}, p};
  endfunction

  task automatic chk40(input string tag, input logic [ACC_W-1:0] act, input logic [ACC_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic go_idle();
    valid_i    = 1'b0;
    load_i     = 1'b0;
    instr_i    = '0;
    mcand_i    = '0;
    mplier_i   = '0;
    flags_i    = '0;
    load_val_i = '0;
  endtask

  task automatic do_load(input logic [ACC_W-1:0] val);
    @(negedge clk);
    load_i = 1'b1; load_val_i = val;
    @(negedge clk);
    load_i = 1'b0;
    exp_acc = val;
  endtask

  // Issue one word; acc_o is sampled one rising edge later.
  task automatic issue(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] f, output logic nm);
    @(negedge clk);
    valid_i = 1'b1; instr_i = w; mcand_i = a; mplier_i = b; flags_i = f;
    #1 nm = nomatch_o;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic t_reset();
    chk40("R1 reset value", acc_o, '0);
    do_load(40'hAB_CDEF_0123);
    @(negedge clk); rst_n = 1'b0;
    #1 chk40("R1 async clear", acc_o, '0);
    @(negedge clk); rst_n = 1'b1;
    exp_acc = '0;
    chk40("R1 after release", acc_o, '0);
  endtask

  task automatic t_load();
    do_load(40'h12_3456_789A);
    chk40("R10 load", acc_o, 40'h12_3456_789A);
  endtask

  task automatic t_basic();
    logic nm;
    do_load('0);
    issue(mk(4'hE, 1'b0, 1'b0), 32'h0000_0003, 32'h0000_0005, 4'h0, nm);
    chk1("R9 match no flag", nm, 1'b0);
    chk40("R2 3*5", acc_o, 40'd15);
    issue(mk(4'hE, 1'b0, 1'b0), 32'h0000_0004, 32'h0000_0002, 4'h0, nm);
    chk40("R2 accumulate 15+8", acc_o, 40'd23);
  endtask

  task automatic t_halves();
    logic nm;
    logic [31:0] a, b;
    a = 32'h0007_FFFD;  // hi 7, lo -3
    b = 32'h0005_0002;  // hi 5, lo 2
    do_load('0);
    issue(mk(4'hE, 1'b1, 1'b0), a, b, 4'h0, nm);
    chk40("R3 hi mcand", acc_o, 40'd14);
    do_load('0);
    issue(mk(4'hE, 1'b0, 1'b0), a, b, 4'h0, nm);
    chk40("R3 lo mcand", acc_o, 40'hFF_FFFF_FFFA);
    do_load('0);
    issue(mk(4'hE, 1'b0, 1'b1), a, b, 4'h0, nm);
    chk40("R4 hi mplier", acc_o, 40'hFF_FFFF_FFF1);
    do_load('0);
    issue(mk(4'hE, 1'b1, 1'b1), a, b, 4'h0, nm);
    chk40("R4 both hi", acc_o, 40'd35);
  endtask

  task automatic t_signed();
    logic nm;
    do_load('0);
    issue(mk(4'hE, 1'b0, 1'b0), 32'h0000_8000, 32'h0000_8000, 4'h0, nm);
    chk40("R5 min*min", acc_o, 40'h00_4000_0000);
    issue(mk(4'hE, 1'b0, 1'b0), 32'h0000_FFFF, 32'h0000_0001, 4'h0, nm);
    chk40("R5 minus one", acc_o, 40'h00_3FFF_FFFF);
    do_load(40'h00_0000_0010);
    issue(mk(4'hE, 1'b1, 1'b0), 32'h8000_0000, 32'h0000_7FFF, 4'h0, nm);
    chk40("R5 sign extend", acc_o, 40'hFF_C000_8010);
  endtask

  task automatic t_wrap();
    logic nm;
    do_load(40'hFF_FFFF_FFFF);
    issue(mk(4'hE, 1'b0, 1'b0), 32'h1, 32'h1, 4'h0, nm);
    chk40("R6 wrap to zero", acc_o, '0);
    do_load(40'h7F_FFFF_FFFF);
    issue(mk(4'hE, 1'b0, 1'b0), 32'h1, 32'h1, 4'h0, nm);
    chk40("R6 carry into top", acc_o, 40'h80_0000_0000);
  endtask

  task automatic t_cond();
    logic nm;
    do_load('0);
    for (int f = 0; f < 16; f++) begin
      for (int c = 0; c < 16; c++) begin
        issue(mk(4'(c), 1'b0, 1'b0), 32'h0000_0001, 32'h0000_0003, 4'(f), nm);
        if (cond_ok(4'(c), 4'(f)))
          exp_acc = exp_acc + product_ext(32'h1, 32'h3, 1'b0, 1'b0);
        chk40($sformatf("R7 cond %0h flags %0h", c, f), acc_o, exp_acc);
      end
    end
  endtask

  task automatic t_nomatch();
    logic nm;
    do_load(40'h00_1111_2222);
    for (int bit_i = 4; bit_i < 28; bit_i++) begin
      if (bit_i >= 12 && bit_i < 18) continue;
      issue(mk(4'hE, 1'b0, 1'b0) ^ (32'h1 << bit_i), 32'h0000_0009, 32'h0000_0009, 4'h0, nm);
      chk1($sformatf("R8 flag bit %0d", bit_i), nm, 1'b1);
      chk40($sformatf("R8 hold bit %0d", bit_i), acc_o, exp_acc);
    end
  endtask

  task automatic t_idle();
    do_load(40'h00_0000_0777);
    @(negedge clk);
    instr_i = 32'hFFFF_FFFF; mcand_i = 32'h7; mplier_i = 32'h7; flags_i = 4'hF;
    #1 chk1("R9 no strobe no flag", nomatch_o, 1'b0);
    @(negedge clk);
    chk40("R11 idle hold", acc_o, exp_acc);
    instr_i = mk(4'hE, 1'b0, 1'b0);
    @(negedge clk);
    chk40("R11 idle good word", acc_o, exp_acc);
    go_idle();
  endtask

  task automatic t_load_prio();
    @(negedge clk);
    valid_i = 1'b1; instr_i = mk(4'hE, 1'b0, 1'b0);
    mcand_i = 32'h64; mplier_i = 32'h64;
    load_i = 1'b1; load_val_i = 40'h55_0000_00AA;
    @(negedge clk);
    valid_i = 1'b0; load_i = 1'b0;
    chk40("R10 load over instr", acc_o, 40'h55_0000_00AA);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0; exp_acc = '0;
    go_idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load();
    t_basic();
    t_halves();
    t_signed();
    t_wrap();
    t_cond();
    t_nomatch();
    t_idle();
    t_load_prio();
    done = 1'b1;
    finish_run();
  end

endmodule